// File: doc/BRIEF.md
# I2S Audio Transmit Channel

This block sends audio samples out on a three-wire serial audio bus: a data line, a bit clock and a word-select line. Software-side logic writes 32-bit sample words into an eight-entry buffer through a simple write strobe. The channel takes words from the buffer and shifts them out MSB first. In master mode it makes the bit clock and word select itself, with one clock toggle per input tick. In slave mode it follows a bit clock and word select driven from outside. The mode can be changed at run time.

The sample width is 8, 16 or 32 bits. In master mode the number of bit clocks in each word-select half is programmable, and the bit slots after the sample are sent as zeros. Stereo framing takes a new word for each half. Mono framing takes one word per frame and sends it in both halves. Mute, stop and soft reset control the channel. Two level comparators raise an interrupt request and a DMA request when the buffer runs low. When the buffer underruns, the channel sends a zero sample and sets a sticky flag.

Top module: `i2stx_top`

## Requirements
- R1: After `rst` or `soft_rst_i`, `sck_o`=0, `ws_o`=1, `sd_o`=0, `level_o`=0 and `underrun_o`=0.
- R2: The buffer holds 8 words. A write while `full_o` is high is dropped and `level_o` stays at 8.
- R3: In master mode (`master_i`=1), `sck_o` toggles once per `tick_i` pulse. `ws_o` changes only on a falling edge of `sck_o`, after `half_m1_i`+1 bit clocks in each half.
- R4: The data line changes on falling bit-clock edges. The sample MSB goes out one bit clock after each word-select edge. Word select low carries the left sample, which is sent first.
- R5: `wsize_i` encodes the sample width: 00 is 8 bits, 01 is 16 bits, 10 and 11 are 32 bits. The sample is taken from the low bits of the buffered word, and any slots after the sample in a half are sent as 0.
- R6: With `stereo_i`=1 every half takes a new buffered word. With `stereo_i`=0 one word is taken at the left half and repeated in the right half.
- R7: In slave mode (`master_i`=0), shifting follows falling edges of `sck_i`, the framing follows `ws_i`, and `clk_oe_o` is 0. In master mode `clk_oe_o` is 1.
- R8: `mute_i` forces `sd_o` to 0, while framing and buffer reads continue.
- R9: `stop_i` freezes the master bit clock, halts buffer reads and holds `sd_o` at 0. Clearing it resumes the frame where it stopped.
- R10: `soft_rst_i` empties the buffer and restarts framing from the idle state of R1.
- R11: `irq_o` is 1 when `level_o` <= `irq_thr_i`. `dma_o` is 1 when `level_o` <= `dma_thr_i`.
- R12: A half that needs a word from an empty buffer is sent as zeros and sets `underrun_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Flush buffer and restart framing |
| master_i | input | 1 | 1 = drive clocks, 0 = follow external clocks |
| stereo_i | input | 1 | 1 = stereo, 0 = mono framing |
| wsize_i | input | 2 | Sample width code |
| half_m1_i | input | 6 | Master half length in bit clocks, minus one |
| mute_i | input | 1 | Force data line low |
| stop_i | input | 1 | Freeze shifting and buffer reads |
| irq_thr_i | input | 4 | Interrupt level threshold |
| dma_thr_i | input | 4 | DMA level threshold |
| wr_en_i | input | 1 | Write strobe for a sample word |
| wr_data_i | input | 32 | Sample word |
| tick_i | input | 1 | Master bit-clock toggle strobe |
| sck_i | input | 1 | External bit clock (slave) |
| ws_i | input | 1 | External word select (slave) |
| sck_o | output | 1 | Bit clock driven in master mode |
| ws_o | output | 1 | Word select driven in master mode |
| clk_oe_o | output | 1 | Clock output enable |
| sd_o | output | 1 | Serial data |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA request |
| level_o | output | 4 | Buffer fill level |
| full_o | output | 1 | Buffer full |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The hardest case to line up from the ports is the boundary where the last sample bit of one half falls into the first slot of the next half. This only happens when the half length equals the sample width, with the word-select edge and that last bit on the same falling edge. The bench reaches it by filling the buffer while stopped, releasing the channel, and rebuilding every half from the data line at rising bit-clock edges in both master and slave modes. Every half length is compared with the programmed one. Underrun zeros are reached by letting each phase drain the buffer completely.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int HALF_W = 6;
    localparam int NB_W   = HALF_W + 1;

    typedef enum logic [1:0] {
        SZ_8   = 2'b00,
        SZ_16  = 2'b01,
        SZ_32  = 2'b10,
        SZ_32X = 2'b11
    } wsize_e;

    typedef struct packed {
        logic              master;
        logic              stereo;
        wsize_e            wsize;
        logic [HALF_W-1:0] half_m1;
        logic              mute;
        logic              stop;
    } ctrl_t;

    // one serial bit event: a falling bit-clock edge and the word select in force after it
    typedef struct packed {
        logic fall;
        logic ws;
    } bitev_t;

    function automatic logic [NB_W-1:0] size_bits(input wsize_e sz);
        case (sz)
            SZ_8:    return NB_W'(8);
            SZ_16:   return NB_W'(16);
            default: return NB_W'(DATA_W);
        endcase
    endfunction

    // bit sent in slot pos of a half: MSB at slot 0, zeros past the sample
    function automatic logic slot_bit(input logic [DATA_W-1:0] w,
                                      input logic [HALF_W-1:0] pos,
                                      input logic [NB_W-1:0]   nb);
        logic [NB_W-1:0] idx;
        if ({1'b0, pos} < nb) begin
            idx = nb - NB_W'(1) - {1'b0, pos};
            return w[idx[IDX_W-1:0]];
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/i2stx_fifo.sv
module i2stx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [LVL_W-1:0] level_q;
    logic             do_push, do_pop;

    assign full    = (level_q == LVL_W'(DEPTH));
    assign empty   = (level_q == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rptr];
    assign level   = level_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr    <= '0;
            rptr    <= '0;
            level_q <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + PTR_W'(1);
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    // R2: level never exceeds the buffer depth
    p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
        level_q <= LVL_W'(DEPTH));

    // R2: outside a flush the level moves by at most one per cycle
    p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(flush) |-> (level_q == $past(level_q)) ||
                          (level_q == $past(level_q) + LVL_W'(1)) ||
                          (level_q + LVL_W'(1) == $past(level_q)));
endmodule

// File: rtl/i2stx_clkgen.sv
module i2stx_clkgen
    import i2stx_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          master,
    input  logic          stop,
    input  logic          tick,
    input  logic [HW-1:0] half_m1,
    input  logic          sck_ext,
    input  logic          ws_ext,
    output bitev_t        ev,
    output logic          sck_q,
    output logic          ws_q
);
    logic          run;
    logic          m_fall;
    logic          wrap;
    logic          ws_next;
    logic          sck_d;
    logic [HW-1:0] cnt;

    assign run     = master & ~stop;
    assign m_fall  = run & tick & sck_q;
    assign wrap    = (cnt >= half_m1);
    assign ws_next = wrap ? ~ws_q : ws_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sck_q <= 1'b0;
            ws_q  <= 1'b1;
            cnt   <= '1;   // forces a word-select edge on the first falling edge
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_ext;
            if (run && tick) sck_q <= ~sck_q;
            if (m_fall) begin
                ws_q <= ws_next;
                cnt  <= wrap ? '0 : cnt + HW'(1);
            end
        end
    end

    always_comb begin
        if (master) begin
            ev.fall = m_fall;
            ev.ws   = ws_next;
        end else begin
            ev.fall = sck_d & ~sck_ext;
            ev.ws   = ws_ext;
        end
    end

    // R3: word select moves only together with a falling bit clock
    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ws_q) && !$past(restart)) |-> $fell(sck_q));
endmodule

// File: rtl/i2stx_serializer.sv
module i2stx_serializer
    import i2stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  bitev_t            ev,
    input  logic              active,
    input  logic              stereo,
    input  wsize_e            wsize,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              sd_q,
    output logic              urun_q
);
    localparam logic [HALF_W-1:0] POS_MAX = '1;

    logic              ws_prev;
    logic [HALF_W-1:0] pos;
    logic [DATA_W-1:0] word;
    logic              raw_q;

    logic              step, edge_ev, take;
    logic [DATA_W-1:0] cur_word;
    logic [HALF_W-1:0] cur_pos;
    logic              raw;

    assign step    = active & ev.fall;
    assign edge_ev = (ev.ws != ws_prev);
    assign take    = step & edge_ev & (stereo | ~ev.ws);
    assign pop     = take & ~fifo_empty;

    always_comb begin
        cur_word = word;
        if (take) cur_word = fifo_empty ? '0 : fifo_data;
        if (edge_ev)             cur_pos = '0;
        else if (pos == POS_MAX) cur_pos = pos;
        else                     cur_pos = pos + HALF_W'(1);
        raw = slot_bit(cur_word, cur_pos, size_bits(wsize));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ws_prev <= 1'b1;
            pos     <= '0;
            word    <= '0;
            raw_q   <= 1'b0;
            sd_q    <= 1'b0;
            urun_q  <= 1'b0;
        end else if (step) begin
            ws_prev <= ev.ws;
            pos     <= cur_pos;
            word    <= cur_word;
            raw_q   <= raw;     // one bit-clock delay after the word-select edge
            sd_q    <= raw_q;
            if (take && fifo_empty) urun_q <= 1'b1;
        end
    end

    // R12: the underrun flag holds until a reset
    p_underrun_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (urun_q && !restart) |=> urun_q);

    // R9: nothing leaves the buffer while the channel is halted
    p_no_pop_halted_r9: assert property (@(posedge clk) disable iff (rst)
        !active |-> !pop);
endmodule

// File: rtl/i2stx_top.sv
module i2stx_top
    import i2stx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_i,
    input  logic              master_i,
    input  logic              stereo_i,
    input  logic [1:0]        wsize_i,
    input  logic [HALF_W-1:0] half_m1_i,
    input  logic              mute_i,
    input  logic              stop_i,
    input  logic [LVL_W-1:0]  irq_thr_i,
    input  logic [LVL_W-1:0]  dma_thr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              tick_i,
    input  logic              sck_i,
    input  logic              ws_i,
    output logic              sck_o,
    output logic              ws_o,
    output logic              clk_oe_o,
    output logic              sd_o,
    output logic              irq_o,
    output logic              dma_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              full_o,
    output logic              underrun_o
);
    ctrl_t             ctl;
    bitev_t            ev;
    logic              sck_int, ws_int;
    logic              fifo_empty, pop, sd_int;
    logic [DATA_W-1:0] fifo_data;
    logic [LVL_W-1:0]  level;

    assign ctl = '{master:  master_i,
                   stereo:  stereo_i,
                   wsize:   wsize_e'(wsize_i),
                   half_m1: half_m1_i,
                   mute:    mute_i,
                   stop:    stop_i};

    i2stx_fifo #(.W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (soft_rst_i),
        .push  (wr_en_i),
        .wdata (wr_data_i),
        .pop   (pop),
        .rdata (fifo_data),
        .level (level),
        .full  (full_o),
        .empty (fifo_empty)
    );

    i2stx_clkgen #(.HW(HALF_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .restart (soft_rst_i),
        .master  (ctl.master),
        .stop    (ctl.stop),
        .tick    (tick_i),
        .half_m1 (ctl.half_m1),
        .sck_ext (sck_i),
        .ws_ext  (ws_i),
        .ev      (ev),
        .sck_q   (sck_int),
        .ws_q    (ws_int)
    );

    i2stx_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .restart    (soft_rst_i),
        .ev         (ev),
        .active     (~ctl.stop),
        .stereo     (ctl.stereo),
        .wsize      (ctl.wsize),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (pop),
        .sd_q       (sd_int),
        .urun_q     (underrun_o)
    );

    assign sck_o      = sck_int & ctl.master;
    assign ws_o       = ws_int;
    assign clk_oe_o   = ctl.master;
    assign sd_o       = sd_int & ~ctl.mute & ~ctl.stop;
    assign level_o    = level;
    assign irq_o      = (level <= irq_thr_i);
    assign dma_o      = (level <= dma_thr_i);

    // R9: a stopped master keeps its bit clock still
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (stop_i && master_i && !soft_rst_i) |=> $stable(sck_int));
endmodule

// File: tb/tb_i2stx_top.sv
module tb_i2stx_top;
    logic        clk = 1'b0;
    logic        rst, soft_rst_i, master_i, stereo_i, mute_i, stop_i;
    logic [1:0]  wsize_i;
    logic [5:0]  half_m1_i;
    logic [3:0]  irq_thr_i, dma_thr_i, level_o;
    logic        wr_en_i, tick_i, sck_i, ws_i;
    logic [31:0] wr_data_i;
    logic        sck_o, ws_o, clk_oe_o, sd_o, irq_o, dma_o, full_o, underrun_o;

    i2stx_top dut (.*);

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- clock sources ----------------
    bit tick_en = 0;
    initial begin
        tick_i = 0;
        forever @(negedge clk) tick_i = tick_en ? ~tick_i : 1'b0;
    end

    bit slave_run = 0;
    int s_half = 8, s_cnt = 0, s_div = 0;
    initial begin
        sck_i = 0; ws_i = 1;
        forever @(negedge clk) if (slave_run) begin
            s_div++;
            if (s_div == 2) begin
                s_div = 0;
                if (sck_i) begin
                    sck_i = 0;
                    s_cnt++;
                    if (s_cnt == s_half) begin s_cnt = 0; ws_i = ~ws_i; end
                end else sck_i = 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    longint unsigned expq[$];
    string  tag = "R4";
    int     wbits = 16, halfn = 16;
    bit     mon_en = 0, skip = 1, last_ws = 1, psck = 0;
    longint unsigned acc = 0;
    int     n = 0;

    task automatic mon_reset();
        last_ws = 1; acc = 0; n = 0; skip = 1; expq.delete();
    endtask

    initial forever begin
        @(negedge clk); #1;
        begin
            bit bsck, bws;
            bsck = master_i ? sck_o : sck_i;
            bws  = master_i ? ws_o : ws_i;
            if (mon_en && bsck && !psck) begin
                acc = (acc << 1) | longint'(sd_o);
                n++;
                if (bws != last_ws) begin
                    if (!skip) begin
                        longint unsigned got, low, exp;
                        exp = (expq.size() != 0) ? expq.pop_front() : 0;
                        got = (acc >> (n - wbits)) & ((64'd1 << wbits) - 1);
                        low = acc & ((64'd1 << (n - wbits)) - 1);
                        chk(n == halfn, {tag, " R3 half length"}, n, halfn);
                        chk(got == exp && low == 0, {tag, " half data"}, got, exp);
                    end
                    skip = 0; acc = 0; n = 0; last_ws = bws;
                end
            end
            psck = bsck;
        end
    end

    // ---------------- driver ----------------
    task automatic push_word(input logic [31:0] d);
        @(negedge clk); wr_en_i = 1; wr_data_i = d;
        @(negedge clk); wr_en_i = 0;
    endtask

    task automatic soft_reset();
        @(negedge clk); soft_rst_i = 1;
        @(negedge clk); soft_rst_i = 0;
    endtask

    task automatic run_phase(input bit mst, input bit st, input logic [1:0] sz, input int h,
                             input bit mu, input int cnt, input logic [31:0] seed, input string t);
        int w;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        stop_i = 1; tick_en = 0; slave_run = 0; mon_en = 0;
        master_i = mst; stereo_i = st; wsize_i = sz; half_m1_i = 6'(h - 1); mute_i = mu;
        sck_i = 0; ws_i = 1; s_half = h; s_cnt = h - 1; s_div = 0;
        soft_reset();
        @(negedge clk);
        chk(underrun_o == 0 && level_o == 0, "R10 flush", {level_o, underrun_o}, 0);
        chk(clk_oe_o == mst, "R7 clock enable", clk_oe_o, mst);
        mon_reset(); wbits = w; halfn = h; tag = t; psck = 0;
        for (int i = 0; i < cnt; i++) begin
            logic [31:0] d;
            d = seed ^ (32'h9E37_79B9 * (i + 1));
            push_word(d);
            expq.push_back(mu ? 0 : longint'(d) & ((64'd1 << w) - 1));
            if (!st) expq.push_back(mu ? 0 : longint'(d) & ((64'd1 << w) - 1));
        end
        mon_en = 1;
        @(negedge clk); stop_i = 0;
        if (mst) tick_en = 1; else slave_run = 1;
        repeat (((st ? cnt : 2 * cnt) + 3) * h * 4 + 40) @(negedge clk);
        chk(expq.size() == 0, {t, " all halves seen"}, expq.size(), 0);
        chk(level_o == 0, "R8 buffer drained", level_o, 0);
        chk(underrun_o == 1, "R12 underrun flag", underrun_o, 1);
        stop_i = 1; tick_en = 0; slave_run = 0; mon_en = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        rst = 1; soft_rst_i = 0; master_i = 1; stereo_i = 1; wsize_i = 2'b01;
        half_m1_i = 6'd15; mute_i = 0; stop_i = 1; irq_thr_i = 0; dma_thr_i = 0;
        wr_en_i = 0; wr_data_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(sck_o == 0 && ws_o == 1 && sd_o == 0, "R1 serial idle", {sck_o, ws_o, sd_o}, 3'b010);
        chk(level_o == 0 && underrun_o == 0, "R1 buffer idle", {level_o, underrun_o}, 0);

        // R11 thresholds and R2 capacity, while stopped
        irq_thr_i = 4'd2; dma_thr_i = 4'd5;
        for (int i = 0; i < 9; i++) begin
            push_word(32'h100 + i);
            @(negedge clk);
            if (i == 1) chk(irq_o == 1 && dma_o == 1, "R11 level 2", {irq_o, dma_o}, 2'b11);
            if (i == 2) chk(irq_o == 0 && dma_o == 1, "R11 level 3", {irq_o, dma_o}, 2'b01);
            if (i == 5) chk(irq_o == 0 && dma_o == 0, "R11 level 6", {irq_o, dma_o}, 2'b00);
        end
        chk(level_o == 8 && full_o == 1, "R2 full after nine writes", level_o, 8);

        // R9 stop freezes, R10 soft reset
        master_i = 1; tick_en = 1;
        repeat (40) @(negedge clk);
        chk(sck_o == 0 && level_o == 8, "R9 no clock while stopped", {sck_o, level_o}, 8);
        stop_i = 0;
        repeat (200) @(negedge clk);
        stop_i = 1;
        @(negedge clk);
        begin
            logic [3:0] lv; logic sk, wv;
            lv = level_o; sk = sck_o; wv = ws_o;
            chk(lv < 8, "R6 words taken while running", lv, 7);
            repeat (100) @(negedge clk);
            chk(level_o == lv && sck_o == sk && ws_o == wv && sd_o == 0,
                "R9 frozen while stopped", {level_o, sck_o, ws_o, sd_o}, {lv, sk, wv, 1'b0});
        end
        tick_en = 0;
        soft_reset();
        @(negedge clk);
        chk(level_o == 0 && sck_o == 0 && ws_o == 1 && underrun_o == 0,
            "R10 restart state", {level_o, sck_o, ws_o, underrun_o}, 6'b000010);

        // framing phases
        run_phase(1, 1, 2'b01, 16, 0, 6, 32'hA5C3_1E77, "R4 R5 R6 stereo16");
        run_phase(1, 1, 2'b00, 12, 0, 5, 32'h1234_5678, "R5 pad8");
        run_phase(1, 0, 2'b10, 32, 0, 3, 32'hDEAD_BEEF, "R6 mono32");
        run_phase(1, 1, 2'b11, 40, 0, 2, 32'h0F0F_F0F0, "R5 code11");
        run_phase(0, 1, 2'b01, 20, 0, 4, 32'h5555_AAAA, "R7 slave16");
        run_phase(1, 1, 2'b01, 16, 1, 3, 32'hFFFF_FFFF, "R8 mute");
        run_phase(0, 0, 2'b00, 8, 0, 3, 32'hC001_D00D, "R7 R6 slave mono8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule